// File: doc/BRIEF.md
# Banked Timer Instruction Memory Arbiter

This block holds the instruction words of a timer execution engine and shares them with a host bus, such as a CPU or a DMA channel. Storage is split into four banks. Consecutive instruction indices rotate through the banks, so an engine stepping linearly through its program moves to a new bank every cycle. Each bank is a two-port memory of 96-bit words, with one read port and one write port. In a single cycle the engine may prefetch one word and write back selected 32-bit fields of another word.

The host sees every 96-bit word as three 32-bit fields, plus a fourth reserved slot, inside a byte-addressed window. The engine always has priority. A host access waits only while the engine is using the same bank in that cycle. Two situations cost the engine a wait state:
- its write-back and its prefetch name the same instruction;
- the host performs a clearing read on the instruction that the engine is writing back.

Top module: `tmr_imem_arb`

## Requirements
- R1: Instruction index `i` (9 bits, 0x000 to 0x1FF) is stored in bank `i[1:0]` at row `i[8:2]`. Every one of the 512 words holds 96 bits.
- R2: Host byte address bits [12:4] give the index and bits [3:2] give the field. Field 0 is word bits [31:0], field 1 is bits [63:32], field 2 is bits [95:64], and field 3 is reserved.
- R3: When `eng_rd_en` is high in a cycle without `eng_wait`, the next cycle shows `eng_rd_valid`=1 and the full 96-bit word at `eng_rd_idx`.
- R4: An engine write updates field k of the word at `eng_wr_idx` only where `eng_wr_fmask[k]`=1. Field 0 uses mask bit 0. The new value is visible to reads from the next cycle on.
- R5: A host access that uses storage gets `host_ready`=1 in the same cycle only if no engine read or write request targets its bank. Otherwise `host_ready` stays 0 and the engine proceeds. The host keeps its request stable until it is granted.
- R6: An engine read and an engine write that name the same index in one cycle raise `eng_wait`. The write is performed, the read is dropped, and `eng_rd_valid` is 0 in the next cycle.
- R7: A granted host read of field 2 returns the old value and then clears field 2 to zero, when bit 0 of field 1 of that word is 1. If `eng_wr_idx` equals that index in the same cycle, the host is granted, `eng_wait`=1, and both engine operations are dropped.
- R8: Host read size 0 returns byte lane `addr[1:0]` zero-extended. Size 1 returns halfword `addr[1]` zero-extended. Sizes 2 and 3 return the whole field.
- R9: A host write with size 0 or 1 completes at once with `host_ready`=1 and changes no stored bit.
- R10: A host write replaces only the addressed 32-bit field. The other two fields of the word keep their values.
- R11: An access to field 3 completes at once whatever the engine does. A read returns 0 and a write is discarded. `host_err` is 1 in that grant cycle only.
- R12: While `rst_n` is low, `host_ready` and `eng_wait` are 0 and nothing is written. `eng_rd_valid` is 0 after reset.
- R13: When no host read is granted, `host_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eng_rd_en | input | 1 | Engine prefetch request |
| eng_rd_idx | input | 9 | Engine prefetch index |
| eng_rd_valid | output | 1 | Prefetched word is present |
| eng_rd_data | output | 96 | Prefetched word |
| eng_wr_en | input | 1 | Engine write-back request |
| eng_wr_idx | input | 9 | Engine write-back index |
| eng_wr_fmask | input | 3 | Per-field write enable |
| eng_wr_data | input | 96 | Engine write-back word |
| eng_wait | output | 1 | Engine wait state in this cycle |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 13 | Host byte address |
| host_size | input | 2 | Host access size code |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | Host access granted this cycle |
| host_rdata | output | 32 | Host read data, valid with `host_ready` |
| host_err | output | 1 | Reserved-field access |

## Verification
A corrupted word or a wrong bank or row choice does not show up until the affected index is read again. It then appears as a wrong `eng_rd_data` one cycle after the prefetch, or as a wrong `host_rdata` in the grant cycle. The bench therefore mirrors all 512 words and compares every read. A mistake in the conflict decision shows at once as a wrong `host_ready` or `eng_wait` in that same cycle, and a wrongly dropped or kept prefetch shows one cycle later on `eng_rd_valid`. Clearing reads and ignored writes are caught on the next read of the touched field.

// File: rtl/tmr_imem_pkg.sv
package tmr_imem_pkg;
   localparam int unsigned FLD_W   = 32;
   localparam int unsigned FLD_NUM = 3;
   localparam int unsigned WORD_W  = FLD_W * FLD_NUM;

   typedef enum logic [1:0] {
      FLD_PROG = 2'd0,
      FLD_CTRL = 2'd1,
      FLD_DATA = 2'd2,
      FLD_RSVD = 2'd3
   } fld_e;

   // Size codes on the host bus: 0 byte, 1 halfword, 2 and 3 word.
   function automatic logic [FLD_W-1:0] lane_pick(input logic [FLD_W-1:0] w,
                                                   input logic [1:0] sz,
                                                   input logic [1:0] boff);
      logic [FLD_W-1:0] r;
      case (sz)
         2'd0:    r = {24'd0, w[{boff, 3'b000} +: 8]};
         2'd1:    r = {16'd0, w[{boff[1], 4'b0000} +: 16]};
         default: r = w;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/tmr_imem_decode.sv
module tmr_imem_decode
   import tmr_imem_pkg::*;
#(
   parameter int unsigned IDX_W     = 9,
   parameter int unsigned BANK_BITS = 2
) (
   input  logic [IDX_W+3:0]           addr,
   output logic [IDX_W-1:0]           idx,
   output logic [BANK_BITS-1:0]       bank,
   output logic [IDX_W-BANK_BITS-1:0] row,
   output fld_e                       fld,
   output logic [1:0]                 boff
);
   assign idx  = addr[IDX_W+3:4];
   assign bank = idx[BANK_BITS-1:0];
   assign row  = idx[IDX_W-1:BANK_BITS];
   assign fld  = fld_e'(addr[3:2]);
   assign boff = addr[1:0];
endmodule

// File: rtl/tmr_imem_bank.sv
module tmr_imem_bank
   import tmr_imem_pkg::*;
#(
   parameter int unsigned ROW_W  = 7,
   parameter int unsigned RC_BIT = 0
) (
   input  logic               clk,
   input  logic [ROW_W-1:0]   rd_row,
   output logic [WORD_W-1:0]  rd_data,
   input  logic               wr_en,
   input  logic [ROW_W-1:0]   wr_row,
   input  logic [FLD_NUM-1:0] wr_fmask,
   input  logic [WORD_W-1:0]  wr_data,
   input  logic [ROW_W-1:0]   flag_row,
   output logic               flag
);
   localparam int unsigned DEPTH = 1 << ROW_W;

   // One storage array per field, so each field lane has its own write enable.
   for (genvar f = 0; f < FLD_NUM; f++) begin : g_fld
      logic [FLD_W-1:0] mem_q [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en && wr_fmask[f]) mem_q[wr_row] <= wr_data[f*FLD_W +: FLD_W];
      end
      assign rd_data[f*FLD_W +: FLD_W] = mem_q[rd_row];
   end

   // Shadow copy of the clear flag. The arbiter can test it without
   // taking the read port.
   logic [DEPTH-1:0] flag_q;
   always_ff @(posedge clk) begin
      if (wr_en && wr_fmask[FLD_CTRL]) flag_q[wr_row] <= wr_data[FLD_W + RC_BIT];
   end
   assign flag = flag_q[flag_row];
endmodule

// File: rtl/tmr_imem_conflict.sv
module tmr_imem_conflict
   import tmr_imem_pkg::*;
#(
   parameter int unsigned IDX_W     = 9,
   parameter int unsigned BANK_BITS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eng_rd_en,
   input  logic [IDX_W-1:0] eng_rd_idx,
   input  logic             eng_wr_en,
   input  logic [IDX_W-1:0] eng_wr_idx,
   input  logic             host_req,
   input  logic             host_we,
   input  logic [IDX_W-1:0] host_idx,
   input  fld_e             host_fld,
   input  logic [1:0]       host_size,
   input  logic             host_flag,
   output logic             eng_rd_go,
   output logic             eng_wr_go,
   output logic             eng_wait,
   output logic             host_go,
   output logic             host_store_rd,
   output logic             host_store_wr,
   output logic             host_clr,
   output logic             host_err
);
   logic same_idx, h_rsvd, h_subwr, h_void, h_rc, rc_hit, bank_busy;
   logic [BANK_BITS-1:0] hb;

   assign hb        = host_idx[BANK_BITS-1:0];
   assign same_idx  = eng_rd_en && eng_wr_en && (eng_rd_idx == eng_wr_idx);
   assign h_rsvd    = (host_fld == FLD_RSVD);
   assign h_subwr   = host_we && !host_size[1];
   assign h_void    = h_rsvd || h_subwr;
   assign h_rc      = host_req && !host_we && (host_fld == FLD_DATA) && host_flag;
   assign rc_hit    = h_rc && eng_wr_en && (eng_wr_idx == host_idx);
   assign bank_busy = (eng_rd_en && (eng_rd_idx[BANK_BITS-1:0] == hb)) ||
                      (eng_wr_en && (eng_wr_idx[BANK_BITS-1:0] == hb));

   assign eng_wait      = rst_n && (same_idx || rc_hit);
   assign eng_rd_go     = rst_n && eng_rd_en && !same_idx && !rc_hit;
   assign eng_wr_go     = rst_n && eng_wr_en && !rc_hit;
   assign host_go       = rst_n && host_req && (h_void || rc_hit || !bank_busy);
   assign host_store_wr = host_go && host_we && !h_void;
   assign host_store_rd = host_go && !host_we && !h_rsvd;
   assign host_clr      = host_store_rd && h_rc;
   assign host_err      = host_go && h_rsvd;

   // R7: a wait that the same-index rule does not explain must come from a granted clearing read.
   a_r7_clear_grants_host: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_wait && !(eng_rd_en && eng_wr_en && eng_rd_idx == eng_wr_idx)) |-> (host_go && host_clr));
   // R5: an engine request on the host bank blocks a store access, except for a clear-read hit.
   a_r5_engine_first: assert property (@(posedge clk) disable iff (!rst_n)
      (host_store_wr && eng_wr_go) |-> (eng_wr_idx[BANK_BITS-1:0] != hb));
endmodule

// File: rtl/tmr_imem_arb.sv
module tmr_imem_arb
   import tmr_imem_pkg::*;
#(
   parameter int unsigned IDX_W     = 9,
   parameter int unsigned BANK_BITS = 2,
   parameter int unsigned RC_BIT    = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               eng_rd_en,
   input  logic [IDX_W-1:0]   eng_rd_idx,
   output logic               eng_rd_valid,
   output logic [WORD_W-1:0]  eng_rd_data,
   input  logic               eng_wr_en,
   input  logic [IDX_W-1:0]   eng_wr_idx,
   input  logic [FLD_NUM-1:0] eng_wr_fmask,
   input  logic [WORD_W-1:0]  eng_wr_data,
   output logic               eng_wait,
   input  logic               host_req,
   input  logic               host_we,
   input  logic [IDX_W+3:0]   host_addr,
   input  logic [1:0]         host_size,
   input  logic [FLD_W-1:0]   host_wdata,
   output logic               host_ready,
   output logic [FLD_W-1:0]   host_rdata,
   output logic               host_err
);
   localparam int unsigned NB    = 1 << BANK_BITS;
   localparam int unsigned ROW_W = IDX_W - BANK_BITS;

   initial begin
      a_cfg_banks: assert (BANK_BITS >= 1 && BANK_BITS < IDX_W)
         else $error("bank bits must leave at least one row bit");
      a_cfg_rcbit: assert (RC_BIT < FLD_W)
         else $error("clear flag bit outside the control field");
      a_cfg_word: assert (WORD_W == FLD_W * FLD_NUM && FLD_NUM == 3)
         else $error("word must hold exactly three host fields");
   end

   logic [IDX_W-1:0]     h_idx;
   logic [BANK_BITS-1:0] h_bank;
   logic [ROW_W-1:0]     h_row;
   fld_e                 h_fld;
   logic [1:0]           h_boff;

   tmr_imem_decode #(.IDX_W(IDX_W), .BANK_BITS(BANK_BITS)) u_dec (
      .addr(host_addr), .idx(h_idx), .bank(h_bank), .row(h_row),
      .fld(h_fld), .boff(h_boff)
   );

   logic                 eng_rd_go, eng_wr_go, host_store_rd, host_store_wr, host_clr;
   logic [NB-1:0]        bank_flag;
   logic [WORD_W-1:0]    bank_rdata [NB];

   tmr_imem_conflict #(.IDX_W(IDX_W), .BANK_BITS(BANK_BITS)) u_cfl (
      .clk(clk), .rst_n(rst_n),
      .eng_rd_en(eng_rd_en), .eng_rd_idx(eng_rd_idx),
      .eng_wr_en(eng_wr_en), .eng_wr_idx(eng_wr_idx),
      .host_req(host_req), .host_we(host_we), .host_idx(h_idx),
      .host_fld(h_fld), .host_size(host_size), .host_flag(bank_flag[h_bank]),
      .eng_rd_go(eng_rd_go), .eng_wr_go(eng_wr_go), .eng_wait(eng_wait),
      .host_go(host_ready), .host_store_rd(host_store_rd),
      .host_store_wr(host_store_wr), .host_clr(host_clr), .host_err(host_err)
   );

   // Host write lane: a clearing read writes zero into the data field only.
   logic [FLD_NUM-1:0] h_fmask;
   logic [WORD_W-1:0]  h_word;
   always_comb begin
      h_fmask = '0;
      h_word  = '0;
      if (host_clr) begin
         h_fmask[FLD_DATA] = 1'b1;
      end else if (h_fld != FLD_RSVD) begin
         h_fmask[h_fld] = 1'b1;
         h_word         = {FLD_NUM{host_wdata}};
      end
   end

   logic [BANK_BITS-1:0] e_rbank, e_wbank;
   assign e_rbank = eng_rd_idx[BANK_BITS-1:0];
   assign e_wbank = eng_wr_idx[BANK_BITS-1:0];

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic             e_rd_here, e_wr_here, h_wr_here, wr_en;
      logic [ROW_W-1:0] rd_row, wr_row;
      logic [FLD_NUM-1:0] wr_fmask;
      logic [WORD_W-1:0]  wr_data;

      assign e_rd_here = eng_rd_go && (e_rbank == BANK_BITS'(b));
      assign e_wr_here = eng_wr_go && (e_wbank == BANK_BITS'(b));
      assign h_wr_here = (host_store_wr || host_clr) && (h_bank == BANK_BITS'(b));
      assign wr_en     = e_wr_here || h_wr_here;
      assign rd_row    = e_rd_here ? eng_rd_idx[IDX_W-1:BANK_BITS] : h_row;
      assign wr_row    = e_wr_here ? eng_wr_idx[IDX_W-1:BANK_BITS] : h_row;
      assign wr_fmask  = e_wr_here ? eng_wr_fmask : h_fmask;
      assign wr_data   = e_wr_here ? eng_wr_data  : h_word;

      tmr_imem_bank #(.ROW_W(ROW_W), .RC_BIT(RC_BIT)) u_bank (
         .clk(clk), .rd_row(rd_row), .rd_data(bank_rdata[b]),
         .wr_en(wr_en), .wr_row(wr_row), .wr_fmask(wr_fmask), .wr_data(wr_data),
         .flag_row(h_row), .flag(bank_flag[b])
      );

      // R5: the write port of one bank never has two owners in a cycle.
      a_r5_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0({e_wr_here, h_wr_here}));
   end

   logic [FLD_W-1:0] h_field;
   assign h_field    = (h_fld == FLD_RSVD) ? '0 : bank_rdata[h_bank][h_fld*FLD_W +: FLD_W];
   assign host_rdata = host_store_rd ? lane_pick(h_field, host_size, h_boff) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eng_rd_valid <= 1'b0;
      else        eng_rd_valid <= eng_rd_go;
   end
   always_ff @(posedge clk) begin
      if (eng_rd_go) eng_rd_data <= bank_rdata[e_rbank];
   end

   // R3: a prefetch without a wait is answered in the next cycle.
   a_r3_prefetch_answered: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rd_en && !eng_wait) |=> eng_rd_valid);
   // R6: a wait cycle never yields prefetch data.
   a_r6_wait_drops_read: assert property (@(posedge clk) disable iff (!rst_n)
      eng_wait |=> !eng_rd_valid);
   // R5: a stalled host keeps its request unchanged.
   a_r5_host_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && !host_ready) |=> (host_req && $stable(host_addr) && $stable(host_we)
                                      && $stable(host_size) && $stable(host_wdata)));
   // R11: the error flag appears only on a granted access and carries no data.
   a_r11_err_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
      host_err |-> (host_ready && host_rdata == '0));
   // R12: nothing is granted while reset is held.
   always_comb begin
      if (!rst_n) begin
         a_r12_idle_in_reset: assert (!host_ready && !eng_wait);
      end
   end
endmodule

// File: tb/tmr_imem_arb_tb.sv
`timescale 1ns/1ps
module tmr_imem_arb_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        eng_rd_en = 1'b0, eng_wr_en = 1'b0;
   logic [8:0]  eng_rd_idx = '0, eng_wr_idx = '0;
   logic [2:0]  eng_wr_fmask = '0;
   logic [95:0] eng_wr_data = '0;
   logic        host_req = 1'b0, host_we = 1'b0;
   logic [12:0] host_addr = '0;
   logic [1:0]  host_size = 2'd2;
   logic [31:0] host_wdata = '0;
   logic        eng_rd_valid, eng_wait, host_ready, host_err;
   logic [95:0] eng_rd_data;
   logic [31:0] host_rdata;

   always #4 clk = ~clk;

   tmr_imem_arb u_dut (
      .clk(clk), .rst_n(rst_n),
      .eng_rd_en(eng_rd_en), .eng_rd_idx(eng_rd_idx),
      .eng_rd_valid(eng_rd_valid), .eng_rd_data(eng_rd_data),
      .eng_wr_en(eng_wr_en), .eng_wr_idx(eng_wr_idx),
      .eng_wr_fmask(eng_wr_fmask), .eng_wr_data(eng_wr_data),
      .eng_wait(eng_wait),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
      .host_size(host_size), .host_wdata(host_wdata),
      .host_ready(host_ready), .host_rdata(host_rdata), .host_err(host_err)
   );

   // Next-cycle stimulus, applied at the falling edge by step().
   bit          n_rst;
   bit          n_rd_en, n_wr_en, n_hreq, n_hwe;
   bit [8:0]    n_rd_idx, n_wr_idx;
   bit [2:0]    n_fmask;
   bit [95:0]   n_wdata;
   bit [12:0]   n_haddr;
   bit [1:0]    n_hsize;
   bit [31:0]   n_hwdata;

   bit [31:0]   m [512][3];
   bit          exp_v;
   bit [95:0]   exp_d;
   bit          got_ready;
   int          n_cmp, n_bad;
   string       ctx = "R12";

   task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", tag, ctx, $time, act, exp);
      end
   endtask

   task automatic step();
      bit [8:0]  hi;
      bit [1:0]  hf;
      bit        same, rsvd, subwr, rc, hit, busy, rdy;
      bit [31:0] w, er;
      string     t;
      @(negedge clk);
      chk("R3", eng_rd_valid, exp_v);
      if (exp_v) chk("R3", eng_rd_data, exp_d);
      rst_n = n_rst; eng_rd_en = n_rd_en; eng_rd_idx = n_rd_idx;
      eng_wr_en = n_wr_en; eng_wr_idx = n_wr_idx; eng_wr_fmask = n_fmask; eng_wr_data = n_wdata;
      host_req = n_hreq; host_we = n_hwe; host_addr = n_haddr; host_size = n_hsize; host_wdata = n_hwdata;
      #1;
      hi    = n_haddr[12:4];
      hf    = n_haddr[3:2];
      same  = n_rd_en && n_wr_en && n_rd_idx == n_wr_idx;
      rsvd  = hf == 2'd3;
      subwr = n_hwe && n_hsize < 2;
      rc    = n_hreq && !n_hwe && hf == 2'd2 && m[hi][1][0];
      hit   = rc && n_wr_en && n_wr_idx == hi;
      busy  = (n_rd_en && n_rd_idx % 4 == hi % 4) || (n_wr_en && n_wr_idx % 4 == hi % 4);
      rdy   = n_rst && n_hreq && (rsvd || subwr || hit || !busy);
      er    = 0;
      if (rdy && !n_hwe && !rsvd) begin
         w = m[hi][hf];
         if (n_hsize == 0)      er = (w >> (8 * n_haddr[1:0])) & 32'hFF;
         else if (n_hsize == 1) er = (w >> (16 * n_haddr[1])) & 32'hFFFF;
         else                   er = w;
      end
      chk("R5", host_ready, rdy);
      t = rsvd ? "R11" : (!rdy || n_hwe) ? "R13" : (n_hsize < 2) ? "R8" : "R2";
      chk(t, host_rdata, er);
      chk("R11", host_err, rdy && rsvd);
      t = same ? "R6" : "R7";
      chk(t, eng_wait, n_rst && (same || hit));
      got_ready = host_ready;
      exp_v = n_rst && n_rd_en && !same && !hit;
      if (exp_v) exp_d = {m[n_rd_idx][2], m[n_rd_idx][1], m[n_rd_idx][0]};
      if (n_rst) begin
         if (n_wr_en && !hit)
            for (int f = 0; f < 3; f++) if (n_fmask[f]) m[n_wr_idx][f] = n_wdata[32*f +: 32];
         if (rdy && n_hwe && !rsvd && !subwr) m[hi][hf] = n_hwdata;
         if (rdy && rc) m[hi][2] = 0;
      end
   endtask

   task automatic idle();
      n_rd_en = 0; n_wr_en = 0; n_hreq = 0; n_hwe = 0; n_hsize = 2;
   endtask

   task automatic hset(input bit we, input bit [8:0] idx, input bit [1:0] f,
                       input bit [1:0] boff, input bit [1:0] sz, input bit [31:0] d);
      n_hreq = 1; n_hwe = we; n_haddr = {idx, f, boff}; n_hsize = sz; n_hwdata = d;
   endtask

   // Hold the host request until it is granted (bounded).
   task automatic host_until_ready();
      for (int k = 0; k < 20; k++) begin
         step();
         if (got_ready) break;
      end
      n_hreq = 0;
   endtask

   function automatic bit [31:0] pat(input int i, input int f);
      bit [31:0] v = 32'h5A00_0000 ^ (i * 32'h0001_0003) ^ (f << 28);
      if (f == 1) v[0] = (i % 5 == 0);
      return v;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      bit pend;
      // R12: reset holds everything idle even with requests present
      idle(); n_rst = 0;
      hset(0, 9'h004, 2'd0, 2'd0, 2'd2, 0); n_rd_en = 1; n_wr_en = 1; n_fmask = 3'b111;
      repeat (3) step();
      idle(); n_rst = 1;
      step();
      // R1: fill all 512 words through the engine write port
      ctx = "R1";
      for (int i = 0; i < 512; i++) begin
         n_wr_en = 1; n_wr_idx = 9'(i); n_fmask = 3'b111;
         n_wdata = {pat(i, 2), pat(i, 1), pat(i, 0)};
         step();
      end
      idle();
      foreach (n_rd_idx[k]) begin end
      n_rd_en = 1; n_rd_idx = 9'h000; step();
      n_rd_idx = 9'h1FF; step();
      n_rd_idx = 9'h0AB; step();
      idle();
      // R2: host field decode at low, high and middle indices
      ctx = "R2";
      for (int f = 0; f < 3; f++) begin
         hset(0, 9'h000, 2'(f), 0, 2, 0); step();
         hset(0, 9'h1FF, 2'(f), 0, 3, 0); step();
         hset(0, 9'h0AB, 2'(f), 0, 2, 0); step();
      end
      idle();
      // R4: engine masked write, then prefetch the same word
      ctx = "R4";
      n_wr_en = 1; n_wr_idx = 9'd5; n_fmask = 3'b010; n_wdata = {32'hAAAA_0002, 32'hBBBB_0010, 32'hCCCC_0000};
      step();
      idle(); n_rd_en = 1; n_rd_idx = 9'd5; step();
      n_wr_en = 1; n_wr_idx = 9'd6; n_fmask = 3'b101; n_rd_idx = 9'd7; step();
      idle(); n_rd_en = 1; n_rd_idx = 9'd6; step();
      // R10: host field write, then read the whole word
      ctx = "R10";
      idle(); hset(1, 9'd7, 2'd1, 0, 2, 32'h1234_5678); step();
      idle(); n_rd_en = 1; n_rd_idx = 9'd7; step();
      hset(1, 9'd11, 2'd2, 0, 2, 32'hDEAD_BEEF); n_rd_en = 0; step();
      idle(); n_rd_en = 1; n_rd_idx = 9'd11; step();
      // R9: sub-word writes are ignored
      ctx = "R9";
      idle(); hset(1, 9'd8, 2'd0, 2'd1, 2'd0, 32'hFFFF_FFFF); step();
      hset(1, 9'd8, 2'd2, 2'd2, 2'd1, 32'hFFFF_FFFF); n_rd_en = 1; n_rd_idx = 9'd8; step();
      idle(); hset(0, 9'd8, 2'd0, 0, 2, 0); step();
      hset(0, 9'd8, 2'd2, 0, 2, 0); step();
      // R8: byte and halfword lanes
      ctx = "R8";
      for (int b = 0; b < 4; b++) begin hset(0, 9'd9, 2'd0, 2'(b), 2'd0, 0); step(); end
      for (int b = 0; b < 4; b += 2) begin hset(0, 9'd9, 2'd1, 2'(b), 2'd1, 0); step(); end
      // R11: reserved field with the engine on the same bank
      ctx = "R11";
      idle(); n_rd_en = 1; n_rd_idx = 9'd12; n_wr_en = 1; n_wr_idx = 9'd16; n_fmask = 3'b001; n_wdata = 96'h1;
      hset(0, 9'd12, 2'd3, 0, 2, 0); step();
      hset(1, 9'd12, 2'd3, 0, 2, 32'h0BAD_0BAD); step();
      idle(); hset(0, 9'd12, 2'd0, 0, 2, 0); step();
      idle(); step();
      // R5: host stalls behind engine use of its bank, then is granted
      ctx = "R5";
      idle(); hset(0, 9'd13, 2'd2, 0, 2, 0);
      n_rd_en = 1; n_rd_idx = 9'd1; step();
      n_rd_idx = 9'd5; step();
      n_rd_en = 0; n_wr_en = 1; n_wr_idx = 9'd9; n_fmask = 3'b001; n_wdata = 96'h77; step();
      n_wr_en = 0; n_rd_en = 1; n_rd_idx = 9'd2; host_until_ready();
      hset(1, 9'd17, 2'd0, 0, 2, 32'h0000_ABCD); n_rd_idx = 9'd21; step();
      n_rd_idx = 9'd22; host_until_ready();
      // R6: write-back and prefetch on the same index
      ctx = "R6";
      idle(); n_rd_en = 1; n_wr_en = 1; n_rd_idx = 9'd20; n_wr_idx = 9'd20;
      n_fmask = 3'b100; n_wdata = {32'h6666_6666, 64'h0}; step();
      n_wr_en = 0; step();
      idle(); step();
      // R7: clearing read, with and without the engine on that word
      ctx = "R7";
      idle(); n_wr_en = 1; n_wr_idx = 9'd10; n_fmask = 3'b001; n_wdata = 96'h99;
      n_rd_en = 1; n_rd_idx = 9'd3; hset(0, 9'd10, 2'd2, 0, 2, 0); step();
      idle(); n_rd_en = 1; n_rd_idx = 9'd10; step();
      idle(); hset(0, 9'd15, 2'd2, 0, 2, 0); step();
      hset(0, 9'd15, 2'd2, 0, 2, 0); step();
      idle(); hset(0, 9'd14, 2'd2, 0, 2, 0); step();
      idle(); step();
      // R13 and R5: mixed random traffic with a well-behaved host
      ctx = "R13";
      pend = 0;
      for (int c = 0; c < 4000; c++) begin
         if (!pend) begin
            if ($urandom_range(3) != 0)
               hset($urandom_range(3) == 0, 9'($urandom_range(511)), 2'($urandom_range(3)),
                    2'($urandom_range(3)), ($urandom_range(4) == 0) ? 2'($urandom_range(1)) : 2'd2,
                    $urandom);
            else n_hreq = 0;
         end
         n_rd_en  = $urandom_range(9) < 6;
         n_rd_idx = 9'($urandom_range(511));
         n_wr_en  = $urandom_range(9) < 4;
         case ($urandom_range(7))
            0:       n_wr_idx = n_rd_idx;
            1:       n_wr_idx = n_haddr[12:4];
            default: n_wr_idx = 9'($urandom_range(511));
         endcase
         n_fmask = 3'($urandom_range(7));
         n_wdata = {$urandom, $urandom, $urandom};
         step();
         pend = n_hreq && !got_ready;
         if (c % 500 == 0) ctx = (c % 1000 == 0) ? "R5" : "R13";
      end
      idle(); step(); step();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule